// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial-bus slave that gives a host read and write access to a small bank of 8-bit configuration registers. The host reaches it over the two open-drain lines SCL and SDA. SCL is observed only, because the slave never stretches the clock. SDA is modelled as an input plus an active-high pull-down enable. One command byte, sent after the address, carries both the access mode and the register offset. Bit 7 of the command set to 1 selects a single-byte access at the offset held in bits 6:0. Bit 7 cleared selects a block access, which always begins at register 0 and carries an explicit byte count.

The design has three parts. A line conditioner synchronises and deglitches both lines and reports SCL edges, start conditions and stop conditions. A protocol state machine handles bit and byte sequencing, acknowledges, byte counting and the offset pointer. A register bank holds power-on defaults and merges read-only status bits into what it reads back.

The state machine has these states:
- S_IDLE: waits for a start condition.
- S_ADDR: shifts in the address byte. A match leads to S_ADDR_ACK; a mismatch leads to S_IGNORE.
- S_ADDR_ACK: for a write, releases SDA and goes to S_CMD; for a read, loads the first byte and goes to S_TX.
- S_CMD and S_CMD_ACK: take in the command. Block mode then goes to S_WCNT; byte mode goes to S_WDATA.
- S_WCNT and S_WCNT_ACK: take in the block byte count, then go to S_WDATA.
- S_WDATA and S_WDATA_ACK: take in data and strobe one register write per byte. A block byte beyond the count goes to S_IGNORE.
- S_TX: shifts a byte out MSB first, then goes to S_RACK.
- S_RACK: samples the master's acknowledge. An ACK leads back to S_TX with the next byte; a NACK leads to S_IGNORE.
- S_IGNORE: waits for a bus condition.

From every state, a start condition goes to S_ADDR and a stop condition goes to S_IDLE.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address `DEV_ADDR` (default 7'h69, so the address bytes are D2h for write and D3h for read). A byte with any other address is not acknowledged, and the slave ignores the bus until the next start condition.
- R2: A command byte with bit 7 = 1 selects byte mode with offset = command bits 6:0. Bit 7 = 0 selects block mode, and its bits 6:0 are disregarded. Every command byte is acknowledged.
- R3: A byte write (D2h, command, data, stop) acknowledges the data byte and stores it in the register at the offset.
- R4: A byte read (D2h, command, repeated start, D3h) returns the register at the offset, MSB first. The master then sends NACK and stop.
- R5: A block write (D2h, command 00h, count, data) stores data bytes in registers 0, 1, 2 and onward. It acknowledges exactly `count` data bytes. A further data byte is not acknowledged and is not written.
- R6: A block read returns first a count byte equal to `NREG`, then registers 0, 1, 2 and onward, for as long as the master acknowledges. The master may stop after any complete byte.
- R7: After reset, every register reads its value from `DEFAULTS` (register i in bits 8i+7:8i).
- R8: Bits set in `RO_MASK` are unaffected by writes, and on reads and on `cfg_q` they show the matching bits of `ro_val`.
- R9: Offsets at or beyond `NREG` read as 00h, and writes to them leave every register unchanged.
- R10: The slave begins pulling SDA low only while the filtered SCL is low.
- R11: A start condition in any state restarts address reception. A stop condition returns the slave to idle with SDA released.
- R12: The internal register write strobe lasts one clock per accepted data byte. Writable register bits change only on that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| ro_val | input | NREG*8 | Values shown in read-only bit positions |
| cfg_q | output | NREG*8 | Current register contents, register i in bits 8i+7:8i |

## Verification
The hardest case to reach is the limit on a block write. Here the slave must accept the count byte, then count down the data bytes, then refuse the first surplus byte and leave the next register untouched. The bench gets there by declaring a count smaller than the number of bytes it sends, then checking both the missing acknowledge and the preserved register contents. A second hard case is a start condition that arrives partway through a command byte. The bench cuts a byte off after a few bits and then issues a repeated start. The clean byte read that follows shows that the partial byte has been discarded.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 7;
    localparam int BIT_W  = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_WCNT,
        S_WCNT_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_TX,
        S_RACK,
        S_IGNORE
    } smb_state_e;

endpackage

// File: rtl/smb_deglitch.sv
module smb_deglitch #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_f
);

    logic [1:0]      sync_q;
    logic [FILT-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_f <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT-2:0], sync_q[1]};
            if (&hist_q) begin
                line_f <= 1'b1;
            end else if (~|hist_q) begin
                line_f <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic scl_q;
    logic sda_q;

    smb_deglitch #(.FILT(FILT)) u_scl (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_i),
        .line_f (scl_f)
    );

    smb_deglitch #(.FILT(FILT)) u_sda (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sda_i),
        .line_f (sda_f)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_evt = scl_f & scl_q & sda_q & ~sda_f;
        stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/smb_cfg_regbank.sv
module smb_cfg_regbank
    import smb_cfg_pkg::*;
#(
    parameter int                    NREG     = 4,
    parameter logic [NREG*BYTE_W-1:0] DEFAULTS = '0,
    parameter logic [NREG*BYTE_W-1:0] RO_MASK  = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OFS_W-1:0]         addr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     we,
    input  logic [NREG*BYTE_W-1:0]   ro_val,
    output logic [BYTE_W-1:0]        rdata,
    output logic [NREG*BYTE_W-1:0]   cfg_q
);

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [BYTE_W-1:0] RO  = RO_MASK[gi*BYTE_W +: BYTE_W];
        localparam logic [BYTE_W-1:0] DEF = DEFAULTS[gi*BYTE_W +: BYTE_W];
        logic [BYTE_W-1:0] store_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q <= DEF & ~RO;
            end else if (we && addr == OFS_W'(gi)) begin
                store_q <= wdata & ~RO;
            end
        end

        assign cfg_q[gi*BYTE_W +: BYTE_W] =
            (store_q & ~RO) | (ro_val[gi*BYTE_W +: BYTE_W] & RO);
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == OFS_W'(i)) begin
                rdata = cfg_q[i*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/smb_cfg_engine.sv
module smb_cfg_engine
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_f,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_evt,
    input  logic               stop_evt,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic [OFS_W-1:0]   reg_addr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_we,
    output smb_state_e         state
);

    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] COUNT_VAL = BYTE_W'(NREG);

    smb_state_e         state_n;
    logic [BIT_W-1:0]   bcnt_q, bcnt_n;
    logic [BYTE_W-1:0]  shreg_q, shreg_n;
    logic [BYTE_W-1:0]  txsh_q, txsh_n;
    logic [OFS_W-1:0]   ptr_q, ptr_n;
    logic [BYTE_W-1:0]  wleft_q, wleft_n;
    logic               blk_q, blk_n;
    logic               cnt_pend_q, cnt_pend_n;
    logic               is_rd_q, is_rd_n;
    logic               mack_q, mack_n;
    logic               sda_oe_n;
    logic [BYTE_W-1:0]  tx_pick;
    logic [2:0]         bidx;

    assign tx_pick = (blk_q && cnt_pend_q) ? COUNT_VAL : rd_data;
    assign bidx    = 3'd7 - bcnt_q[2:0];

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            bcnt_q     <= '0;
            shreg_q    <= '0;
            txsh_q     <= '0;
            ptr_q      <= '0;
            wleft_q    <= '0;
            blk_q      <= 1'b1;
            cnt_pend_q <= 1'b1;
            is_rd_q    <= 1'b0;
            mack_q     <= 1'b0;
            sda_oe     <= 1'b0;
        end else begin
            state      <= state_n;
            bcnt_q     <= bcnt_n;
            shreg_q    <= shreg_n;
            txsh_q     <= txsh_n;
            ptr_q      <= ptr_n;
            wleft_q    <= wleft_n;
            blk_q      <= blk_n;
            cnt_pend_q <= cnt_pend_n;
            is_rd_q    <= is_rd_n;
            mack_q     <= mack_n;
            sda_oe     <= sda_oe_n;
        end
    end

    // next state, datapath updates and write strobe
    always_comb begin
        state_n    = state;
        bcnt_n     = bcnt_q;
        shreg_n    = shreg_q;
        txsh_n     = txsh_q;
        ptr_n      = ptr_q;
        wleft_n    = wleft_q;
        blk_n      = blk_q;
        cnt_pend_n = cnt_pend_q;
        is_rd_n    = is_rd_q;
        mack_n     = mack_q;
        sda_oe_n   = sda_oe;
        reg_we     = 1'b0;

        if (start_evt) begin
            state_n  = S_ADDR;
            bcnt_n   = '0;
            sda_oe_n = 1'b0;
        end else if (stop_evt) begin
            state_n  = S_IDLE;
            bcnt_n   = '0;
            sda_oe_n = 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: begin
                    sda_oe_n = 1'b0;
                end

                S_ADDR, S_CMD, S_WCNT, S_WDATA: begin
                    if (scl_rise && bcnt_q != LAST_BIT) begin
                        shreg_n = {shreg_q[BYTE_W-2:0], sda_f};
                        bcnt_n  = bcnt_q + 1'b1;
                    end else if (scl_fall && bcnt_q == LAST_BIT) begin
                        bcnt_n = '0;
                        if (state == S_ADDR) begin
                            if (shreg_q[7:1] == DEV_ADDR) begin
                                sda_oe_n = 1'b1;
                                is_rd_n  = shreg_q[0];
                                state_n  = S_ADDR_ACK;
                            end else begin
                                state_n = S_IGNORE;
                            end
                        end else if (state == S_CMD) begin
                            sda_oe_n   = 1'b1;
                            blk_n      = ~shreg_q[7];
                            ptr_n      = shreg_q[7] ? shreg_q[OFS_W-1:0] : '0;
                            cnt_pend_n = 1'b1;
                            state_n    = S_CMD_ACK;
                        end else if (state == S_WCNT) begin
                            sda_oe_n = 1'b1;
                            wleft_n  = shreg_q;
                            state_n  = S_WCNT_ACK;
                        end else begin
                            if (!blk_q || wleft_q != '0) begin
                                sda_oe_n = 1'b1;
                                reg_we   = 1'b1;
                                ptr_n    = ptr_q + 1'b1;
                                if (blk_q) begin
                                    wleft_n = wleft_q - 1'b1;
                                end
                                state_n = S_WDATA_ACK;
                            end else begin
                                state_n = S_IGNORE;
                            end
                        end
                    end
                end

                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (is_rd_q) begin
                            txsh_n   = tx_pick;
                            sda_oe_n = ~tx_pick[7];
                            bcnt_n   = BIT_W'(1);
                            state_n  = S_TX;
                        end else begin
                            sda_oe_n = 1'b0;
                            state_n  = S_CMD;
                        end
                    end
                end

                S_CMD_ACK: begin
                    if (scl_fall) begin
                        sda_oe_n = 1'b0;
                        state_n  = blk_q ? S_WCNT : S_WDATA;
                    end
                end

                S_WCNT_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe_n = 1'b0;
                        state_n  = S_WDATA;
                    end
                end

                S_TX: begin
                    if (scl_fall) begin
                        if (bcnt_q != LAST_BIT) begin
                            sda_oe_n = ~txsh_q[bidx];
                            bcnt_n   = bcnt_q + 1'b1;
                        end else begin
                            sda_oe_n = 1'b0;
                            bcnt_n   = '0;
                            state_n  = S_RACK;
                            if (blk_q && cnt_pend_q) begin
                                cnt_pend_n = 1'b0;
                            end else begin
                                ptr_n = ptr_q + 1'b1;
                            end
                        end
                    end
                end

                S_RACK: begin
                    if (scl_rise) begin
                        mack_n = ~sda_f;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            txsh_n   = tx_pick;
                            sda_oe_n = ~tx_pick[7];
                            bcnt_n   = BIT_W'(1);
                            state_n  = S_TX;
                        end else begin
                            state_n = S_IGNORE;
                        end
                    end
                end
            endcase
        end
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = shreg_q;

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0]             DEV_ADDR = 7'h69,
    parameter int                     NREG     = 4,
    parameter int                     FILT     = 3,
    parameter logic [NREG*BYTE_W-1:0] DEFAULTS = 32'hFF_5A_E0_00,
    parameter logic [NREG*BYTE_W-1:0] RO_MASK  = 32'h00_00_1F_00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [NREG*BYTE_W-1:0] ro_val,
    output logic [NREG*BYTE_W-1:0] cfg_q
);

    logic               scl_f;
    logic               sda_f;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_evt;
    logic               stop_evt;
    logic [OFS_W-1:0]   reg_addr;
    logic [BYTE_W-1:0]  reg_wdata;
    logic [BYTE_W-1:0]  reg_rdata;
    logic               reg_we;
    smb_state_e         eng_state;

    smb_line_cond #(.FILT(FILT)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    smb_cfg_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .state     (eng_state)
    );

    smb_cfg_regbank #(.NREG(NREG), .DEFAULTS(DEFAULTS), .RO_MASK(RO_MASK)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .we     (reg_we),
        .ro_val (ro_val),
        .rdata  (reg_rdata),
        .cfg_q  (cfg_q)
    );

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
#(
    parameter int                     NREG    = 4,
    parameter logic [NREG*BYTE_W-1:0] RO_MASK = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_f,
    input logic                   sda_oe,
    input logic                   reg_we,
    input logic                   start_evt,
    input logic                   stop_evt,
    input smb_state_e             state,
    input logic [NREG*BYTE_W-1:0] cfg_q
);

    localparam logic [NREG*BYTE_W-1:0] WMASK = ~RO_MASK;

    // R10
    sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R11
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == S_ADDR) && !sda_oe);

    // R11
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == S_IDLE) && !sda_oe);

    // R11
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);

    // R12
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R12
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(cfg_q & WMASK));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .RO_MASK(RO_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .state     (eng_state),
    .cfg_q     (cfg_q)
);

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;

    localparam int          NREG  = 4;
    localparam int          Q     = 10;
    localparam logic [31:0] DEF   = 32'hFF_5A_E0_00;
    localparam logic [31:0] RO    = 32'h00_00_1F_00;
    localparam logic [31:0] ROV   = 32'h00_00_0A_00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [31:0] cfg_q;
    logic        sda_bus;
    logic [7:0]  mdl [NREG];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    smb_cfg_slave u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .ro_val (ROV),
        .cfg_q  (cfg_q)
    );

    function automatic logic [7:0] exp_reg(int i);
        return (mdl[i] & ~RO[i*8 +: 8]) | (ROV[i*8 +: 8] & RO[i*8 +: 8]);
    endfunction

    function automatic logic [7:0] exp_rd(int o);
        return (o < NREG) ? exp_reg(o) : 8'h00;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_cfg(string req);
        for (int i = 0; i < NREG; i++) begin
            chk(req, cfg_q[i*8 +: 8], exp_reg(i));
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic wbyte(logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rbyte(logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_bus; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = ~give_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    // block read of n bytes after the count; checks count and data
    task automatic blk_read(logic [7:0] cmd, int n, string req);
        logic       a;
        logic [7:0] b;
        bus_start();
        wbyte(8'hD2, a); chk("R1", a, 1);
        wbyte(cmd, a);   chk("R2", a, 1);
        bus_rstart();
        wbyte(8'hD3, a); chk("R1", a, 1);
        rbyte(n != 0, b); chk(req, b, NREG);
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, b);
            chk(req, b, exp_rd(i));
        end
        bus_stop();
    endtask

    initial begin : main
        logic       a;
        logic [7:0] b;
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) mdl[i] = DEF[i*8 +: 8];
        wq(5);
        chk("R11", sda_oe, 0);
        rst_n = 1'b1;
        wq(5);
        // R7: defaults after reset, R8 read-only merge
        chk_cfg("R7");
        blk_read(8'h00, NREG, "R7");

        // R2 R3 R4 R9 R10: byte write/read sweep over offsets and patterns
        for (int o = 0; o < NREG + 2; o++) begin
            for (int k = 0; k < 2; k++) begin
                v = 8'(o * 59) ^ (k != 0 ? 8'hFF : 8'h5C);
                bus_start();
                wbyte(8'hD2, a); chk("R1", a, 1);
                wbyte(8'h80 | 8'(o), a); chk("R2", a, 1);
                wbyte(v, a); chk("R3", a, 1);
                bus_stop();
                if (o < NREG) mdl[o] = v;
                chk_cfg(o < NREG ? "R8" : "R9");
                bus_start();
                wbyte(8'hD2, a);
                wbyte(8'h80 | 8'(o), a);
                bus_rstart();
                wbyte(8'hD3, a); chk("R1", a, 1);
                rbyte(1'b0, b);
                bus_stop();
                chk(o < NREG ? "R4" : "R9", b, exp_rd(o));
            end
        end

        // R1: foreign addresses are not acknowledged and the bus is ignored
        for (int k = 0; k < 4; k++) begin
            v = (k == 0) ? 8'hD0 : (k == 1) ? 8'hD6 : (k == 2) ? 8'h52 : 8'hD3 ^ 8'h80;
            bus_start();
            wbyte(v, a); chk("R1", a, 0);
            wbyte(8'h81, a); chk("R1", a, 0);
            wbyte(8'h00, a); chk("R1", a, 0);
            bus_stop();
            chk_cfg("R1");
        end

        // R5: block write of all registers
        bus_start();
        wbyte(8'hD2, a); wbyte(8'h00, a); chk("R2", a, 1);
        wbyte(8'(NREG), a); chk("R5", a, 1);
        for (int i = 0; i < NREG; i++) begin
            v = 8'h11 * 8'(i + 3);
            wbyte(v, a); chk("R5", a, 1);
            mdl[i] = v;
        end
        bus_stop();
        chk_cfg("R5");
        blk_read(8'h00, NREG, "R6");

        // R5: count of 2, third byte refused and not written
        bus_start();
        wbyte(8'hD2, a); wbyte(8'h00, a);
        wbyte(8'd2, a); chk("R5", a, 1);
        wbyte(8'hC3, a); chk("R5", a, 1);
        wbyte(8'h3C, a); chk("R5", a, 1);
        wbyte(8'h99, a); chk("R5", a, 0);
        bus_stop();
        mdl[0] = 8'hC3; mdl[1] = 8'h3C;
        chk_cfg("R5");

        // R6: block command with nonzero low bits still starts at 0; early stops
        blk_read(8'h05, 2, "R6");
        blk_read(8'h00, 0, "R6");
        blk_read(8'h7F, NREG + 1, "R6");

        // R11: start in the middle of a command byte
        bus_start();
        wbyte(8'hD2, a);
        send_bits(8'h82, 3);
        bus_rstart();
        wbyte(8'hD2, a); chk("R11", a, 1);
        wbyte(8'h82, a);
        bus_rstart();
        wbyte(8'hD3, a);
        rbyte(1'b0, b);
        bus_stop();
        chk("R11", b, exp_rd(2));
        wq(5);
        chk("R11", sda_oe, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule